// File: doc/BRIEF.md
# Current-Level Sequence Player

This block drives the level code of one current-sink channel from a queue of packed level words. A host writes 32-bit words into a 16-entry queue. The player splits each word into sixteen 2-bit slots, starting with the least significant slot, and holds each slot on the `level` output for a programmed period. When no word is playing, the output carries the default level from the configuration word.

A single configuration register sets the default level, the slot period, the channel mode and the playback style. In free-running style, queued words play one after another with no gap between them. In manual style, each word starts only after the host sets the trigger bit, and that bit clears itself when the word begins. The analog sink, host address decoding and all other protocols are handled outside this block.

The slot period counts ticks of a timebase. One tick lasts `TICK_DIV` clock cycles. With the default of 50, one tick is 1 µs on a 50 MHz clock.

Top module: `lvlseq_player`

## Requirements
- R1: Level codes are 01 = LOW, 10 = MID, 11 = HIGH and 00 = sink off. Each queue word plays as 16 slots, from bits 1:0 up to bits 31:30. For example, 0x5555_557B plays HIGH, MID, HIGH and then 13 LOW slots.
- R2: Each slot stays on `level` for exactly P × TICK_DIV clock cycles, where P is configuration bits 15:0. A P of 0 behaves as 1.
- R3: While the channel is enabled and no word is playing, `level` equals configuration bits 31:30.
- R4: The queue holds DEPTH (16) words. `full` is set when 16 words are stored, `empty` is set when none are stored, and both are never set together. A word is taken from the queue only when playback starts.
- R5: A push while the queue is full is dropped and sets the sticky `overflow` flag. The flag is cleared only by a configuration write with bit 27 set. A push into a full queue wins over a clear in the same cycle.
- R6: The channel mode field is configuration bits 17:16. Only the value 1 enables playback. Any other value forces `level` to 00 and `busy` to 0, and leaves the queue contents untouched. Pushes are still accepted while the channel is disabled.
- R7: When manual style is selected (bit 28 = 1), a word starts only while the trigger bit 29 reads 1. The trigger bit clears itself when the word starts. After the word ends, the output returns to the default level until the next trigger.
- R8: When free-running style is selected (bit 28 = 0), queued words play back to back. The first slot of the next word follows the last slot of the previous word in the very next cycle.
- R9: After reset, `cfg_q` is 0, `level` is 00, `busy` is 0, `overflow` is 0, `empty` is 1 and `full` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_wr | input | 1 | Push strobe for the queue |
| fifo_wdata | input | WORD_W | Packed level word to push |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data. Fields: 31:30 default level, 29 trigger, 28 manual style, 27 overflow clear, 17:16 mode, 15:0 slot period |
| cfg_q | output | 32 | Configuration readback. Bit 27 always reads 0 |
| level | output | 2 | Current-sink level code |
| busy | output | 1 | A word is being played |
| empty | output | 1 | Queue holds no word |
| full | output | 1 | Queue holds DEPTH words |
| overflow | output | 1 | Sticky flag: a push was dropped |

## Verification
The bench builds the block with DEPTH = 16 and TICK_DIV = 2. With these values it can fill the queue to its full depth, push one word past full, and then drain all sixteen words inside the cycle budget. Slot periods of 0, 1 and 3 ticks become 2, 2 and 6 clock cycles, so the bench can count every cycle of every slot exactly. This also shows that a period of 0 behaves as 1 and that there is no gap between back-to-back words.

// File: rtl/lvlseq_player.sv
module lvlseq_player #(
  parameter int DEPTH    = 16,
  parameter int WORD_W   = 32,
  parameter int TICK_DIV = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_wr,
  input  logic [WORD_W-1:0] fifo_wdata,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_q,
  output logic [1:0]        level,
  output logic              busy,
  output logic              empty,
  output logic              full,
  output logic              overflow
);
  localparam int AW    = $clog2(DEPTH);
  localparam int SLOTS = WORD_W / 2;
  localparam int SW    = $clog2(SLOTS);
  localparam int PW    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW:0]       wptr, rptr;
  logic [1:0]        dflt, mode;
  logic              trig, manual;
  logic [15:0]       period;

  logic              playing;
  logic [WORD_W-1:0] sh;
  logic [SW-1:0]     slot;
  logic [PW-1:0]     pre;
  logic [15:0]       cnt;

  wire [AW:0] used    = wptr - rptr;
  wire        run_en  = (mode == 2'd1);
  wire [15:0] per_eff = (period == 16'd0) ? 16'd1 : period;
  wire        tick_end  = (pre == PW'(TICK_DIV - 1));
  wire        slot_end  = playing && tick_end && (cnt == per_eff - 16'd1);
  wire        word_end  = slot_end && (slot == SW'(SLOTS - 1));
  wire        can_start = run_en && !empty && (!manual || trig);
  wire        load      = can_start && (!playing || word_end);
  wire        push_ok   = fifo_wr && !full;

  assign empty = (used == '0);
  assign full  = (used == (AW+1)'(DEPTH));
  assign busy  = playing && run_en;
  assign level = !run_en ? 2'b00 : (playing ? sh[1:0] : dflt);
  assign cfg_q = {dflt, trig, manual, 1'b0, 9'd0, mode, period};

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr[AW-1:0]] <= fifo_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (load)    rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dflt   <= 2'b00;
      trig   <= 1'b0;
      manual <= 1'b0;
      mode   <= 2'b00;
      period <= 16'd0;
    end else if (cfg_wr) begin
      dflt   <= cfg_wdata[31:30];
      trig   <= cfg_wdata[29];
      manual <= cfg_wdata[28];
      mode   <= cfg_wdata[17:16];
      period <= cfg_wdata[15:0];
    end else if (load && manual) begin
      trig   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overflow <= 1'b0;
    else if (fifo_wr && full) overflow <= 1'b1;
    else if (cfg_wr && cfg_wdata[27]) overflow <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      playing <= 1'b0;
      sh      <= '0;
      slot    <= '0;
      pre     <= '0;
      cnt     <= '0;
    end else if (!run_en) begin
      playing <= 1'b0;
      slot    <= '0;
      pre     <= '0;
      cnt     <= '0;
    end else if (load) begin
      playing <= 1'b1;
      sh      <= mem[rptr[AW-1:0]];
      slot    <= '0;
      pre     <= '0;
      cnt     <= '0;
    end else if (word_end) begin
      playing <= 1'b0;
    end else if (playing) begin
      if (tick_end) begin
        pre <= '0;
        if (slot_end) begin
          cnt  <= '0;
          slot <= slot + 1'b1;
          sh   <= sh >> 2;
        end else begin
          cnt  <= cnt + 16'd1;
        end
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lvlseq_player_chk.sv
module lvlseq_player_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fifo_wr,
  input logic        cfg_wr,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_q,
  input logic [1:0]  level,
  input logic        busy,
  input logic        empty,
  input logic        full,
  input logic        overflow
);
  // R4
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n) !(full && empty));
  // R4
  start_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(!empty));
  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n) (fifo_wr && full) |=> overflow);
  // R5
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !(cfg_wr && cfg_wdata[27])) |=> overflow);
  // R6
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[17:16] != 2'd1) |-> (!busy && level == 2'b00));
  // R7
  manual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[28] && !cfg_q[29] && !busy) |=> !busy);
  // R7
  trig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(cfg_q[28]) && !$past(cfg_wr)) |-> !cfg_q[29]);
endmodule

bind lvlseq_player lvlseq_player_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_wr(fifo_wr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .cfg_q(cfg_q), .level(level), .busy(busy), .empty(empty), .full(full), .overflow(overflow)
);

// File: tb/lvlseq_player_test.sv
module lvlseq_player_test;
  localparam int CLK_PERIOD = 10;
  localparam int TD = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_wr = 1'b0;
  logic [31:0] fifo_wdata = '0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_q;
  logic [1:0]  level;
  logic        busy, empty, full, overflow;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvlseq_player #(.DEPTH(16), .WORD_W(32), .TICK_DIV(TD)) uut (
    .clk(clk), .rst_n(rst_n), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q), .level(level),
    .busy(busy), .empty(empty), .full(full), .overflow(overflow)
  );

  function automatic logic [31:0] mk(input logic [1:0] d, input logic tr, input logic man,
                                     input logic clr, input logic [1:0] md, input logic [15:0] per);
    return {d, tr, man, clr, 9'd0, md, per};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(posedge clk); #1 fifo_wr = 1'b1; fifo_wdata = w;
    @(posedge clk); #1 fifo_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic cfg(input logic [31:0] w);
    @(posedge clk); #1 cfg_wr = 1'b1; cfg_wdata = w;
    @(posedge clk); #1 cfg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic play_word(input logic [31:0] w, input int per, input string req);
    int pd;
    int guard;
    pd = ((per == 0) ? 1 : per) * TD;
    guard = 0;
    while (!busy && guard < 1000) begin @(negedge clk); guard++; end
    check({req, " start"}, {31'd0, busy}, 32'd1);
    if (busy) begin
      for (int i = 0; i < 16*pd; i++) begin
        check(req, {30'd0, level}, {30'd0, w[2*(i/pd) +: 2]});
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset;
    check("R9 cfg_q", cfg_q, 32'd0);
    check("R9 level", {30'd0, level}, 32'd0);
    check("R9 busy", {31'd0, busy}, 32'd0);
    check("R9 overflow", {31'd0, overflow}, 32'd0);
    check("R9 empty", {31'd0, empty}, 32'd1);
    check("R9 full", {31'd0, full}, 32'd0);
  endtask

  task automatic t_disabled_then_order;
    push(32'h5555_557B);
    cfg(mk(2'b11, 1'b0, 1'b0, 1'b0, 2'd0, 16'd1));
    idle(20);
    check("R6 mode0 level off", {30'd0, level}, 32'd0);
    check("R6 mode0 queue kept", {31'd0, empty}, 32'd0);
    cfg(mk(2'b11, 1'b0, 1'b0, 1'b0, 2'd2, 16'd1));
    idle(20);
    check("R6 mode2 busy", {31'd0, busy}, 32'd0);
    check("R6 mode2 level off", {30'd0, level}, 32'd0);
    cfg(mk(2'b11, 1'b0, 1'b0, 1'b0, 2'd1, 16'd1));
    play_word(32'h5555_557B, 1, "R1 slot order");
    check("R3 default HIGH", {30'd0, level}, 32'd3);
    check("R3 idle busy", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_period;
    cfg(mk(2'b10, 1'b0, 1'b0, 1'b0, 2'd1, 16'd3));
    push(32'h1B1B_E4E4);
    play_word(32'h1B1B_E4E4, 3, "R2 period 3");
    check("R3 default MID", {30'd0, level}, 32'd2);
    cfg(mk(2'b01, 1'b0, 1'b0, 1'b0, 2'd1, 16'd0));
    push(32'hC3A5_0F96);
    play_word(32'hC3A5_0F96, 0, "R2 period 0 as 1");
    check("R3 default LOW", {30'd0, level}, 32'd1);
  endtask

  task automatic t_back_to_back;
    cfg(mk(2'b01, 1'b0, 1'b0, 1'b0, 2'd0, 16'd2));
    push(32'h9C6D_27E1);
    push(32'h36F0_D84B);
    cfg(mk(2'b01, 1'b0, 1'b0, 1'b0, 2'd1, 16'd2));
    play_word(32'h9C6D_27E1, 2, "R8 first word");
    check("R8 no gap busy", {31'd0, busy}, 32'd1);
    play_word(32'h36F0_D84B, 2, "R8 second word");
    check("R8 drained", {31'd0, empty}, 32'd1);
  endtask

  task automatic t_full_overflow;
    cfg(mk(2'b10, 1'b0, 1'b0, 1'b0, 2'd0, 16'd1));
    for (int i = 0; i < 16; i++) push(32'h0123_4567 ^ (32'h1111_1111 * i));
    check("R4 full at 16", {31'd0, full}, 32'd1);
    check("R4 not empty", {31'd0, empty}, 32'd0);
    check("R5 no overflow yet", {31'd0, overflow}, 32'd0);
    push(32'hFFFF_FFFF);
    check("R5 overflow set", {31'd0, overflow}, 32'd1);
    check("R5 still full", {31'd0, full}, 32'd1);
    cfg(mk(2'b10, 1'b0, 1'b0, 1'b0, 2'd0, 16'd1));
    check("R5 sticky", {31'd0, overflow}, 32'd1);
    cfg(mk(2'b10, 1'b0, 1'b0, 1'b1, 2'd0, 16'd1));
    check("R5 cleared", {31'd0, overflow}, 32'd0);
    check("R5 clear bit reads 0", {31'd0, cfg_q[27]}, 32'd0);
    cfg(mk(2'b10, 1'b0, 1'b0, 1'b0, 2'd1, 16'd1));
    for (int i = 0; i < 16; i++) play_word(32'h0123_4567 ^ (32'h1111_1111 * i), 1, "R4 drain");
    check("R5 dropped word absent", {31'd0, busy}, 32'd0);
    check("R4 empty after drain", {31'd0, empty}, 32'd1);
    check("R3 default after drain", {30'd0, level}, 32'd2);
  endtask

  task automatic t_manual;
    cfg(mk(2'b01, 1'b0, 1'b1, 1'b0, 2'd0, 16'd1));
    push(32'hE4E4_1B1B);
    push(32'h7D28_B3C6);
    cfg(mk(2'b01, 1'b0, 1'b1, 1'b0, 2'd1, 16'd1));
    idle(20);
    check("R7 waits for trigger", {31'd0, busy}, 32'd0);
    check("R7 default while waiting", {30'd0, level}, 32'd1);
    cfg(mk(2'b01, 1'b1, 1'b1, 1'b0, 2'd1, 16'd1));
    play_word(32'hE4E4_1B1B, 1, "R7 first triggered word");
    check("R7 trigger self-clear", {31'd0, cfg_q[29]}, 32'd0);
    idle(20);
    check("R7 stops after one word", {31'd0, busy}, 32'd0);
    check("R7 default between words", {30'd0, level}, 32'd1);
    check("R7 second word kept", {31'd0, empty}, 32'd0);
    cfg(mk(2'b01, 1'b1, 1'b1, 1'b0, 2'd1, 16'd1));
    play_word(32'h7D28_B3C6, 1, "R7 second triggered word");
    check("R7 empty at end", {31'd0, empty}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled_then_order();
    t_period();
    t_back_to_back();
    t_full_overflow();
    t_manual();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule